// File: doc/BRIEF.md
# RTC Seconds Prescaler with Trim

This block divides a fixed-frequency count clock down to a one-second tick. Each second normally lasts `SEC_CYCLES` count-enabled input cycles. A host-written trim register holds a 6-bit magnitude and a 2-bit direction code. When a correction is applied, the register shortens or lengthens exactly one second by the magnitude, so the accumulated time can be pulled back toward the true time.

The register can trigger corrections in two ways:

- **Manual mode.** Each accepted write arms one correction. The correction is applied to the next full second.
- **Automatic mode.** Writes only update the stored value. The block itself applies the correction once every 60 or once every 10 seconds, according to an interval select input.

A busy flag marks the final cycle of every second. A pending flag covers the time from arming a correction to the end of the corrected second. A write is accepted only while counting is enabled and both flags are low.

Top module: `rtc_trim_prescaler`

## Requirements
- R1: With no correction active, consecutive `sec_tick` pulses are `SEC_CYCLES` count-enabled cycles apart, and each pulse is one cycle wide.
- R2: Direction code `wr_data[7:6]` = 01 (subtract) makes the corrected second last `SEC_CYCLES` minus the magnitude `wr_data[5:0]`.
- R3: Direction code `wr_data[7:6]` = 10 (add) makes the corrected second last `SEC_CYCLES` plus the magnitude `wr_data[5:0]`.
- R4: Direction codes 00 and 11 apply no correction and never raise `pending`, although the written value is stored and visible on `trim_q`.
- R5: With `auto_en` = 0, an accepted write with a valid direction raises `pending` in the next cycle. The correction is applied to the first second that starts after the write. `pending` falls when that second ends, and later seconds are nominal.
- R6: With `auto_en` = 1, a write never raises `pending`. With `auto_sel` = 1, corrected seconds recur exactly every 10 seconds.
- R7: With `auto_en` = 1 and `auto_sel` = 0, corrected seconds recur exactly every 60 seconds.
- R8: While `count_en` = 0, writes are ignored and the seconds count halts, so no `sec_tick` appears.
- R9: `busy` is high only during the last cycle of each second, and `sec_tick` follows in the next cycle. A write made while `busy` or `pending` is high leaves `trim_q` unchanged.
- R10: Reset (`rst`) and the RTC software reset (`soft_rst`) clear `trim_q` and `pending`. After `soft_rst`, counting restarts from the beginning of a second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock |
| rst | input | 1 | Synchronous active-high system reset |
| soft_rst | input | 1 | Synchronous RTC software reset |
| count_en | input | 1 | Count source enable; also gates register writes |
| auto_en | input | 1 | 1 selects automatic periodic correction |
| auto_sel | input | 1 | Automatic interval: 1 = every 10 s, 0 = every 60 s |
| wr_en | input | 1 | Trim register write strobe |
| wr_data | input | 8 | [5:0] magnitude, [7:6] direction code |
| trim_q | output | 8 | Trim register contents |
| sec_tick | output | 1 | One-cycle pulse per elapsed second |
| busy | output | 1 | High in the final cycle of each second |
| pending | output | 1 | A correction is armed or in progress |

## Verification
A wrong second counter or a wrong length select appears directly in the spacing of `sec_tick`. The first tick after the fault is off by the error amount, within one second. A stuck or mis-sequenced correction flag shows up on `pending` within one cycle of an accepted write, or at the end of the corrected second. In automatic mode it appears as uneven spacing between corrected seconds, so the bench measures whole intervals of 10 and 60 seconds. Write gating faults appear on `trim_q` in the cycle after the blocked write.

// File: rtl/rtc_trim_pkg.sv
package rtc_trim_pkg;
    localparam int MAG_W = 6;

    typedef enum logic [1:0] {
        DIR_NONE = 2'b00,
        DIR_SUB  = 2'b01,
        DIR_ADD  = 2'b10,
        DIR_RSV  = 2'b11
    } trim_dir_e;

    typedef struct packed {
        trim_dir_e        dir;
        logic [MAG_W-1:0] mag;
    } trim_cfg_t;

    function automatic logic dir_valid(trim_dir_e d);
        return (d == DIR_SUB) || (d == DIR_ADD);
    endfunction
endpackage

// File: rtl/rtc_trim_reg.sv
module rtc_trim_reg
    import rtc_trim_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      soft_rst,
    input  logic      wr_en,
    input  trim_cfg_t wr_cfg,
    input  logic      count_en,
    input  logic      busy,
    input  logic      pend,
    output trim_cfg_t cfg,
    output logic      wr_accept
);
    assign wr_accept = wr_en && count_en && !busy && !pend;

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            cfg <= '0;
        end else if (wr_accept) begin
            cfg <= wr_cfg;
        end
    end

    AST_WR_BLOCKED: assert property (@(posedge clk) disable iff (rst || soft_rst)
        (wr_en && (busy || pend || !count_en)) |=> $stable(cfg)); // R9
    AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (cfg == '0)); // R10
endmodule

// File: rtl/rtc_sec_divider.sv
module rtc_sec_divider
    import rtc_trim_pkg::*;
#(
    parameter int unsigned SEC_CYCLES = 32768
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      soft_rst,
    input  logic      count_en,
    input  trim_cfg_t cfg,
    input  logic      act,
    output logic      rollover,
    output logic      busy,
    output logic      sec_tick
);
    localparam int unsigned MAX_LEN = SEC_CYCLES + (1 << MAG_W) - 1;
    localparam int         CW      = $clog2(MAX_LEN + 1);
    localparam logic [CW-1:0] NOM_LAST = CW'(SEC_CYCLES - 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    always_comb begin
        last = NOM_LAST;
        if (act) begin
            case (cfg.dir)
                DIR_SUB: last = NOM_LAST - CW'(cfg.mag);
                DIR_ADD: last = NOM_LAST + CW'(cfg.mag);
                default: last = NOM_LAST;
            endcase
        end
    end

    assign rollover = count_en && (cnt >= last);
    assign busy     = rollover;

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            cnt      <= '0;
            sec_tick <= 1'b0;
        end else begin
            sec_tick <= rollover;
            if (rollover) begin
                cnt <= '0;
            end else if (count_en) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst || soft_rst)
        sec_tick |=> !sec_tick); // R1
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst || soft_rst)
        cnt <= last); // R1
    AST_HALT: assert property (@(posedge clk) disable iff (rst || soft_rst)
        !count_en |=> $stable(cnt)); // R8
endmodule

// File: rtl/rtc_corr_ctrl.sv
module rtc_corr_ctrl
    import rtc_trim_pkg::*;
#(
    parameter int unsigned LONG_SECS  = 60,
    parameter int unsigned SHORT_SECS = 10
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      soft_rst,
    input  logic      auto_en,
    input  logic      auto_sel,
    input  logic      rollover,
    input  logic      wr_accept,
    input  trim_dir_e wr_dir,
    input  trim_dir_e cur_dir,
    output logic      pend,
    output logic      act
);
    localparam int unsigned MAX_SECS = (LONG_SECS > SHORT_SECS) ? LONG_SECS : SHORT_SECS;
    localparam int          SW       = $clog2(MAX_SECS);
    localparam logic [SW-1:0] LONG_LAST  = SW'(LONG_SECS - 1);
    localparam logic [SW-1:0] SHORT_LAST = SW'(SHORT_SECS - 1);

    logic [SW-1:0] scnt;
    logic [SW-1:0] ilast;
    logic          due;

    assign ilast = auto_sel ? SHORT_LAST : LONG_LAST;
    assign due   = auto_en && (scnt >= ilast) && dir_valid(cur_dir);

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            scnt <= '0;
            pend <= 1'b0;
            act  <= 1'b0;
        end else begin
            if (!auto_en) begin
                scnt <= '0;
            end else if (rollover) begin
                scnt <= (scnt >= ilast) ? '0 : scnt + 1'b1;
            end

            if (rollover) begin
                if (act) begin
                    act  <= 1'b0;
                    pend <= 1'b0;
                end else if (pend) begin
                    act <= 1'b1;
                end else if (due) begin
                    pend <= 1'b1;
                    act  <= 1'b1;
                end
            end else if (wr_accept && !auto_en && dir_valid(wr_dir)) begin
                pend <= 1'b1;
            end
        end
    end

    AST_ACT_PEND: assert property (@(posedge clk) disable iff (rst || soft_rst)
        act |-> pend); // R5
    AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (rst || soft_rst)
        (rollover && act) |=> (!pend && !act)); // R5
    AST_AUTO_NO_ARM: assert property (@(posedge clk) disable iff (rst || soft_rst)
        (auto_en && !pend && !rollover) |=> !pend); // R6
    AST_RSV_NO_CORR: assert property (@(posedge clk) disable iff (rst || soft_rst)
        (!dir_valid(cur_dir)) |-> !act); // R4
endmodule

// File: rtl/rtc_trim_prescaler.sv
module rtc_trim_prescaler
    import rtc_trim_pkg::*;
#(
    parameter int unsigned SEC_CYCLES = 32768,
    parameter int unsigned LONG_SECS  = 60,
    parameter int unsigned SHORT_SECS = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       soft_rst,
    input  logic       count_en,
    input  logic       auto_en,
    input  logic       auto_sel,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] trim_q,
    output logic       sec_tick,
    output logic       busy,
    output logic       pending
);
    trim_cfg_t wr_cfg;
    trim_cfg_t cfg;
    logic      wr_accept;
    logic      rollover;
    logic      act;

    assign wr_cfg  = trim_cfg_t'(wr_data);
    assign trim_q  = cfg;

    rtc_trim_reg u_reg (
        .clk       (clk),
        .rst       (rst),
        .soft_rst  (soft_rst),
        .wr_en     (wr_en),
        .wr_cfg    (wr_cfg),
        .count_en  (count_en),
        .busy      (busy),
        .pend      (pending),
        .cfg       (cfg),
        .wr_accept (wr_accept)
    );

    rtc_sec_divider #(.SEC_CYCLES(SEC_CYCLES)) u_div (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (soft_rst),
        .count_en (count_en),
        .cfg      (cfg),
        .act      (act),
        .rollover (rollover),
        .busy     (busy),
        .sec_tick (sec_tick)
    );

    rtc_corr_ctrl #(.LONG_SECS(LONG_SECS), .SHORT_SECS(SHORT_SECS)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .soft_rst  (soft_rst),
        .auto_en   (auto_en),
        .auto_sel  (auto_sel),
        .rollover  (rollover),
        .wr_accept (wr_accept),
        .wr_dir    (wr_cfg.dir),
        .cur_dir   (cfg.dir),
        .pend      (pending),
        .act       (act)
    );
endmodule

// File: tb/sim_rtc_trim_prescaler.sv
`timescale 1ns/1ps
module sim_rtc_trim_prescaler;
    localparam int NOM = 100;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       soft_rst = 1'b0;
    logic       count_en = 1'b1;
    logic       auto_en = 1'b0;
    logic       auto_sel = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] trim_q;
    logic       sec_tick, busy, pending;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    rtc_trim_prescaler #(.SEC_CYCLES(NOM), .LONG_SECS(60), .SHORT_SECS(10)) u0 (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .count_en(count_en),
        .auto_en(auto_en), .auto_sel(auto_sel), .wr_en(wr_en), .wr_data(wr_data),
        .trim_q(trim_q), .sec_tick(sec_tick), .busy(busy), .pending(pending)
    );

    // {write data, expected corrected second length, expected pending}
    localparam logic [23:0] VEC [7] = '{
        {8'h45, 8'd95,  8'd1},   // R2 subtract 5
        {8'h8A, 8'd110, 8'd1},   // R3 add 10
        {8'h7F, 8'd37,  8'd1},   // R2 subtract 63
        {8'hBF, 8'd163, 8'd1},   // R3 add 63
        {8'h00, 8'd100, 8'd0},   // R4 code 00
        {8'hC7, 8'd100, 8'd0},   // R4 code 11
        {8'h40, 8'd100, 8'd1}    // R5 subtract zero still arms
    };

    task automatic chk(input string req, input int actual, input int expected);
        n_chk++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic wait_tick(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!sec_tick);
    endtask

    task automatic do_write(input logic [7:0] d);
        @(negedge clk);
        while (busy || pending) @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic raw_write(input logic [7:0] d);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        int len;
        int idx_prev;
        int n_corr;
        int ticks;
        logic [7:0] held;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 reset trim_q", trim_q, 0);
        chk("R10 reset pending", pending, 0);
        chk("R1 reset tick", sec_tick, 0);
        chk("R9 reset busy", busy, 0);

        wait_tick(len);
        wait_tick(len);
        chk("R1 nominal second", len, NOM);

        // manual-mode vector walk
        for (int i = 0; i < 7; i++) begin
            do_write(VEC[i][23:16]);
            chk("R5 trim_q after write", trim_q, VEC[i][23:16]);
            chk("R4/R5 pending after write", pending, VEC[i][7:0]);
            wait_tick(len);
            chk("R5 pending during corrected second", pending, VEC[i][7:0]);
            wait_tick(len);
            chk("R2/R3/R4 corrected length", len, VEC[i][15:8]);
            chk("R5 pending cleared", pending, 0);
            wait_tick(len);
            chk("R5 following second nominal", len, NOM);
        end

        // busy window and write blocked while busy
        held = trim_q;
        @(negedge clk);
        while (!busy) @(negedge clk);
        raw_write(8'h8A);
        chk("R9 busy one cycle", busy, 0);
        chk("R9 tick after busy", sec_tick, 1);
        chk("R9 write during busy ignored", trim_q, held);
        chk("R9 no pending from busy write", pending, 0);

        // write blocked while pending
        do_write(8'h45);
        chk("R5 pending set", pending, 1);
        raw_write(8'h8A);
        chk("R9 write during pending ignored", trim_q, 8'h45);
        wait_tick(len);
        wait_tick(len);
        chk("R2 corrected after blocked write", len, 95);

        // count enable low
        @(negedge clk);
        count_en = 1'b0;
        raw_write(8'h83);
        chk("R8 write with count off ignored", trim_q, 8'h45);
        chk("R8 no pending with count off", pending, 0);
        ticks = 0;
        for (int c = 0; c < 300; c++) begin
            @(negedge clk);
            if (sec_tick) ticks++;
        end
        chk("R8 no ticks with count off", ticks, 0);
        count_en = 1'b1;

        // soft reset
        do_write(8'h8A);
        chk("R5 armed before soft reset", pending, 1);
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
        chk("R10 soft reset trim_q", trim_q, 0);
        chk("R10 soft reset pending", pending, 0);
        wait_tick(len);
        chk("R10 first second after soft reset", len, NOM);

        // automatic mode, 10 s interval
        auto_en = 1'b1;
        auto_sel = 1'b1;
        do_write(8'h85);
        chk("R6 trim_q in auto", trim_q, 8'h85);
        chk("R6 write does not arm in auto", pending, 0);
        wait_tick(len);
        idx_prev = -1;
        n_corr = 0;
        for (int s = 0; s < 25; s++) begin
            wait_tick(len);
            if (len == 105) begin
                if (idx_prev >= 0) chk("R6 auto spacing 10", s - idx_prev, 10);
                idx_prev = s;
                n_corr++;
            end else begin
                chk("R6 uncorrected second", len, NOM);
            end
        end
        chk("R6 corrections in 25 s", (n_corr >= 2) ? 1 : 0, 1);

        // automatic mode, 60 s interval
        auto_sel = 1'b0;
        idx_prev = -1;
        n_corr = 0;
        for (int s = 0; s < 130; s++) begin
            wait_tick(len);
            if (len == 105) begin
                if (idx_prev >= 0) chk("R7 auto spacing 60", s - idx_prev, 60);
                idx_prev = s;
                n_corr++;
            end else begin
                chk("R7 uncorrected second", len, NOM);
            end
        end
        chk("R7 corrections in 130 s", (n_corr >= 2) ? 1 : 0, 1);

        // reserved code in automatic mode
        auto_sel = 1'b1;
        do_write(8'hC5);
        chk("R4 reserved stored", trim_q, 8'hC5);
        wait_tick(len);
        n_corr = 0;
        for (int s = 0; s < 12; s++) begin
            wait_tick(len);
            if (len != NOM) n_corr++;
            if (pending) n_corr++;
        end
        chk("R4 reserved no correction in auto", n_corr, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule